// File: doc/BRIEF.md
# Pin Change Interrupt Controller

This block watches a group of input pins, eight by default, and raises one interrupt request when an enabled pin shows its chosen active edge. Software sets, pin by pin, whether detection is on and whether the active edge is rising or falling. A global enable masks or passes the request. A single sticky flag records that an edge was seen. Software clears the flag by writing 1 to an acknowledge bit.

Each pin passes through a two-flop synchroniser. The block compares the synchronised level with the pin's active level, gated by the pin's enable, and it detects an edge when that term changes from false to true. So turning a pin on while its level is already active sets the flag, and so does changing its polarity to match the present level. Software is expected to acknowledge after it configures the pins. The block also drives a pull enable and a pull direction to the pad logic for each pin, taken from the same configuration.

The register interface is a write strobe, an address, write data and combinational read data.

Top module: `pin_change_irq`

## Requirements
- R1: `irq` is high exactly when the flag is set and the global enable (offset 0 bit 1) is 1. The flag still sets while the global enable is 0.
- R2: Polarity bit 1 selects rising-edge detection and 0 selects falling-edge detection. The inactive transition never sets the flag. A pin change made between two clock edges shows in the flag after the third rising clock edge that follows it.
- R3: A pin whose enable bit (offset 1) is 0 never sets the flag, whatever its input does.
- R4: Writing offset 0 with bit 2 set clears the flag. Bit 2 always reads as 0.
- R5: Setting a pin's enable, or changing its polarity, while its synchronised level equals the newly active level sets the flag, as if an edge had been seen.
- R6: `pull_en` equals the pin enable bits. `pull_up` is 1 for an enabled pin with falling polarity and 0 for every other pin, which selects pull-down for enabled rising-edge pins.
- R7: If an edge is detected in the same cycle as an acknowledge write, the flag stays set.
- R8: The register map is as follows. Offset 0 reads the flag at bit 3 (read-only) and the global enable at bit 1, and all its other bits read 0. Offset 1 holds the pin enables, offset 2 holds the polarity bits, and offset 3 reads 0. Everything resets to 0.
- R9: Once set, the flag, and the `irq` when the global enable is 1, stays until an acknowledge write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| pin_in | input | 8 | Asynchronous pin levels |
| irq | output | 1 | Interrupt request |
| pull_en | output | 8 | Per-pin pull enable to the pad |
| pull_up | output | 8 | Per-pin pull direction, 1 = up |

## Verification
A wrong synchroniser or previous-sample state shows up as a flag that appears one cycle early or late, or not at all, relative to the three-edge latency. The reference model compares `irq` and the read data on every clock, so the cycle where they diverge pins down the fault. A flag that is stuck, or that is cleared when it should not be, shows on `irq` in the first cycle after the acknowledge write or the edge concerned. Wrong enable or polarity storage shows at once on `pull_en`, on `pull_up` and on the read data.

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
  parameter int N_PINS = 8,
  parameter int AW     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic              irq,
  output logic [N_PINS-1:0] pull_en,
  output logic [N_PINS-1:0] pull_up
);
  localparam logic [AW-1:0] CTL_A = AW'(0);
  localparam logic [AW-1:0] EN_A  = AW'(1);
  localparam logic [AW-1:0] POL_A = AW'(2);
  localparam int IE_B  = 1;
  localparam int ACK_B = 2;
  localparam int FLG_B = 3;

  logic [N_PINS-1:0] sync1, sync2, act_q, pin_en, pin_pol, act, edge_hit;
  logic irq_en, flag, edge_any, wr_ctl, ack;

  assign act      = pin_en & ~(sync2 ^ pin_pol);
  assign edge_hit = act & ~act_q;
  assign edge_any = |edge_hit;
  assign wr_ctl   = wr_en && (addr == CTL_A);
  assign ack      = wr_ctl && wdata[ACK_B];
  assign irq      = flag & irq_en;
  assign pull_en  = pin_en;
  assign pull_up  = pin_en & ~pin_pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      act_q <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      act_q <= act;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en  <= 1'b0;
      pin_en  <= '0;
      pin_pol <= '0;
    end else if (wr_en) begin
      if (addr == CTL_A) irq_en  <= wdata[IE_B];
      if (addr == EN_A)  pin_en  <= wdata[N_PINS-1:0];
      if (addr == POL_A) pin_pol <= wdata[N_PINS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (edge_any) flag <= 1'b1;
    else if (ack)      flag <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      CTL_A: begin
        rdata[FLG_B] = flag;
        rdata[IE_B]  = irq_en;
      end
      EN_A:    rdata = 8'(pin_en);
      POL_A:   rdata = 8'(pin_pol);
      default: rdata = '0;
    endcase
  end
endmodule

module pin_change_irq_chk #(
  parameter int N_PINS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flag,
  input logic              edge_any,
  input logic              ack,
  input logic [N_PINS-1:0] pin_en
);
  assert_edge_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    edge_any |=> flag);
  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !edge_any) |=> !flag);
  assert_flag_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !ack) |=> flag);
  assert_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(|pin_en));
  assert_rise_from_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(edge_any));
endmodule

bind pin_change_irq pin_change_irq_chk #(.N_PINS(N_PINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .flag(flag), .edge_any(edge_any),
  .ack(ack), .pin_en(pin_en)
);

// File: tb/pin_change_irq_tb.sv
module pin_change_irq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, pins = '0, rdata, pull_en, pull_up;
  logic irq;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  pin_change_irq dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pins), .irq(irq), .pull_en(pull_en), .pull_up(pull_up)
  );

  logic [7:0] m_s1, m_s2, m_aq, m_en, m_pol;
  logic m_ie, m_flag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_aq = 0; m_en = 0; m_pol = 0; m_ie = 0; m_flag = 0;
    end else begin
      logic hit;
      logic [7:0] na;
      hit = 0;
      for (int i = 0; i < 8; i++) begin
        na[i] = m_en[i] && (m_s2[i] == m_pol[i]);
        if (na[i] && !m_aq[i]) hit = 1;
      end
      m_aq = na; m_s2 = m_s1; m_s1 = pins;
      if (hit) m_flag = 1;
      else if (wr_en && addr == 0 && wdata[2]) m_flag = 0;
      if (wr_en) begin
        if (addr == 0) m_ie = wdata[1];
        if (addr == 1) m_en = wdata;
        if (addr == 2) m_pol = wdata;
      end
    end
  end

  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return {4'b0, m_flag, 1'b0, m_ie, 1'b0};
      2'd1: return m_en;
      2'd2: return m_pol;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check("R1 irq vs model", {7'b0, irq}, {7'b0, m_flag & m_ie});
    check("R8 rdata vs model", rdata, m_read(addr));
    check("R6 pull_en vs model", pull_en, m_en);
    check("R6 pull_up vs model", pull_up, m_en & ~m_pol);
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #5; wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #5; wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(posedge clk); #5; addr = a;
    @(negedge clk); v = rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #5;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    #35 rst_n = 1;
    rd(0, v); check("R8 reset ctl", v, 8'h00);
    rd(1, v); check("R8 reset en", v, 8'h00);
    rd(2, v); check("R8 reset pol", v, 8'h00);
    rd(3, v); check("R8 offset3", v, 8'h00);
    check("R1 reset irq", {7'b0, irq}, 8'h00);

    wr(2, 8'h0F);
    wr(1, 8'hFF);
    settle(3);
    rd(0, v); check("R5 spurious on enable, R1 ie clear", v, 8'h08);
    check("R1 irq masked", {7'b0, irq}, 8'h00);
    check("R6 pull_up", pull_up, 8'hF0);
    check("R6 pull_en", pull_en, 8'hFF);
    wr(0, 8'h04);
    rd(0, v); check("R4 ack clears, reads 0", v, 8'h00);
    wr(0, 8'h06);
    rd(0, v); check("R4 ack bit reads 0 with ie", v, 8'h02);

    @(posedge clk); #5; pins = 8'h01;
    settle(4); check("R2 rising edge", {7'b0, irq}, 8'h01);
    settle(6); check("R9 irq holds", {7'b0, irq}, 8'h01);
    wr(0, 8'h06); settle(1);
    check("R4 irq cleared", {7'b0, irq}, 8'h00);

    @(posedge clk); #5; pins = 8'h11;
    settle(4); check("R2 inactive rise on falling pin", {7'b0, irq}, 8'h00);
    @(posedge clk); #5; pins = 8'h01;
    settle(4); check("R2 falling edge", {7'b0, irq}, 8'h01);
    wr(0, 8'h06);

    wr(1, 8'h01);
    @(posedge clk); #5; pins = 8'h81;
    settle(4);
    @(posedge clk); #5; pins = 8'h01;
    settle(4); check("R3 disabled pin ignored", {7'b0, irq}, 8'h00);

    wr(1, 8'h03);
    settle(3); check("R5 enable at inactive level", {7'b0, irq}, 8'h00);
    wr(2, 8'h0D);
    settle(3); check("R5 polarity change", {7'b0, irq}, 8'h01);
    check("R6 pull_up after pol", pull_up, 8'h02);
    wr(0, 8'h06);
    @(posedge clk); #5; pins = 8'h03;
    settle(4); check("R2 inactive rise pin1", {7'b0, irq}, 8'h00);

    @(posedge clk); #5; pins = 8'h01;
    @(posedge clk); @(posedge clk); #5;
    wr_en = 1; addr = 0; wdata = 8'h06;
    @(posedge clk); #5; wr_en = 0;
    settle(1); check("R7 edge beats ack", {7'b0, irq}, 8'h01);
    wr(0, 8'h04);
    rd(0, v); check("R1 flag clear, ie clear", v, 8'h00);

    settle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule